// File: doc/BRIEF.md
# Scheduled Timer Event Matcher

The block compares one stored 72-bit schedule entry with a running calendar clock. It evaluates the entry only in a cycle where the minute tick is high. The clock supplies a minute count from 0 to 119, the hour count divided by two (0 to 11), a 9-bit day of year and a weekday index. The entry packs a weekday mask, a first and last day of year, a start time, a stop time and two 12-bit pointers. Some of these fields are split across bit ranges that do not sit next to each other.

When both day tests pass and the current minute of the day equals the start time or the stop time, the block offers the matching pointer on a valid/ready output. A flag on that output tells a start event from a stop event. A surrounding walker loads one entry after another and consumes the pointers.

Back-pressure rules are as follows. A result stays on the output until the cycle in which `ev_ready` is high. While a result is held and not accepted, tick evaluations produce nothing and are lost. In a cycle where the held result is accepted, a tick can load a new result at the same edge.

Top module: `timer_event_match`

## Requirements
- R1: While `rst_n` is low, `ev_valid` is low.
- R2: The first day is `{entry[39], entry[63:56]}` and the last day is `{entry[31], entry[55:48]}`. The day test passes only when first ≤ `clk_yday` ≤ last, both ends inclusive.
- R3: The weekday mask is `entry[70:64]`. Bit k enables weekday index k, where 0 is Sunday and 6 is Saturday. Index 7 never passes. `entry[71]` has no effect.
- R4: The start time in minutes is `entry[47:44]`×120 + `entry[38:32]`. The stop time is `entry[43:40]`×120 + `entry[30:24]`. The current time is `clk_hr2`×120 + `clk_min`. Matches are exact equality of these sums.
- R5: A start match emits pointer `{entry[23:20], entry[15:8]}` with `ev_is_stop` = 0. A stop match emits `{entry[19:16], entry[7:0]}` with `ev_is_stop` = 1.
- R6: When start time equals stop time, only the start pointer is emitted for that minute.
- R7: The entry is evaluated only on a cycle with `min_tick` high. The result appears on the output in the cycle after that tick edge. With no tick, no new result appears.
- R8: While `ev_valid` is high and `ev_ready` is low, `ev_valid`, `ev_ptr` and `ev_is_stop` hold, and a tick in that time is discarded. A tick in the cycle where the held result is accepted loads its own result.
- R9: A result needs both the weekday test and the day-of-year test to pass. Neither one alone is enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| min_tick | input | 1 | One-cycle pulse marking a new minute |
| clk_min | input | 7 | Minute within the two-hour unit, 0 to 119 |
| clk_hr2 | input | 4 | Hours divided by two, 0 to 11 |
| clk_yday | input | 9 | Day of year |
| clk_wday | input | 3 | Weekday index, 0 = Sunday |
| entry | input | 72 | Schedule entry under test |
| ev_valid | output | 1 | Result available |
| ev_ready | input | 1 | Consumer accepts the result |
| ev_ptr | output | 12 | Pointer of the triggered event |
| ev_is_stop | output | 1 | 1 for a stop event, 0 for a start event |

## Verification
The bench targets the following corner cases:
- **Day range ends.** It probes the first and last day with the ninth bit set, and the day just outside each end. A design that drops the split high day bit, or uses a strict comparison, fires on the wrong days.
- **Minute offsets above 119.** It uses offsets such as 1×120+1 against 0×120+121. A design that compares unit and offset fields separately instead of summed minutes misses these matches.
- **Day tests and weekday index 7.** It applies entries that pass only one of the two day tests, and weekday index 7. An OR of the tests, or an unguarded mask index, produces spurious events.
- **Equal start and stop times.** A design without start priority reports a stop event here.
- **Stall handling.** A stall with a tick arriving during it shows whether a held result gets overwritten.

// File: rtl/tme_pkg.sv
package tme_pkg;
  localparam int ENTRY_W = 72;
  localparam int UNIT_W  = 4;
  localparam int OFS_W   = 7;
  localparam int DAY_W   = 9;
  localparam int PTR_W   = 12;
  localparam int WDAY_W  = 3;
  localparam int NDAYS   = 7;

  typedef struct packed {
    logic [NDAYS-1:0]  wmask;
    logic [DAY_W-1:0]  day_first;
    logic [DAY_W-1:0]  day_last;
    logic [UNIT_W-1:0] on_units;
    logic [OFS_W-1:0]  on_ofs;
    logic [UNIT_W-1:0] off_units;
    logic [OFS_W-1:0]  off_ofs;
    logic [PTR_W-1:0]  on_ptr;
    logic [PTR_W-1:0]  off_ptr;
  } sched_t;
endpackage

// File: rtl/tme_field_unpack.sv
module tme_field_unpack
  import tme_pkg::*;
(
  input  logic [ENTRY_W-1:0] raw,
  output sched_t             fld
);
  // Reassemble split fields; bit 71 is left unused.
  always_comb begin
    fld.wmask     = raw[70:64];
    fld.day_first = {raw[39], raw[63:56]};
    fld.day_last  = {raw[31], raw[55:48]};
    fld.on_units  = raw[47:44];
    fld.off_units = raw[43:40];
    fld.on_ofs    = raw[38:32];
    fld.off_ofs   = raw[30:24];
    fld.on_ptr    = {raw[23:20], raw[15:8]};
    fld.off_ptr   = {raw[19:16], raw[7:0]};
  end
endmodule

// File: rtl/tme_minute_calc.sv
module tme_minute_calc
  import tme_pkg::*;
#(
  parameter int UNIT_MIN = 120,
  parameter int TIME_W   = 11
) (
  input  logic [UNIT_W-1:0] units,
  input  logic [OFS_W-1:0]  ofs,
  output logic [TIME_W-1:0] minutes
);
  logic [TIME_W-1:0] u_ext;
  logic [TIME_W-1:0] o_ext;
  always_comb begin
    u_ext   = TIME_W'(units);
    o_ext   = TIME_W'(ofs);
    minutes = u_ext * TIME_W'(UNIT_MIN) + o_ext;
  end
endmodule

// File: rtl/tme_day_gate.sv
module tme_day_gate
  import tme_pkg::*;
(
  input  logic [NDAYS-1:0]  wmask,
  input  logic [WDAY_W-1:0] wday,
  input  logic [DAY_W-1:0]  yday,
  input  logic [DAY_W-1:0]  first,
  input  logic [DAY_W-1:0]  last,
  output logic              pass
);
  logic wk_hit;
  logic in_range;
  always_comb begin
    wk_hit = 1'b0;
    for (int k = 0; k < NDAYS; k++) begin
      if (wday == WDAY_W'(k)) wk_hit = wk_hit | wmask[k];
    end
    in_range = (yday >= first) && (yday <= last);
    pass     = wk_hit && in_range;
  end
endmodule

// File: rtl/timer_event_match.sv
module timer_event_match
  import tme_pkg::*;
#(
  parameter int UNIT_MIN = 120
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                min_tick,
  input  logic [OFS_W-1:0]    clk_min,
  input  logic [UNIT_W-1:0]   clk_hr2,
  input  logic [DAY_W-1:0]    clk_yday,
  input  logic [WDAY_W-1:0]   clk_wday,
  input  logic [ENTRY_W-1:0]  entry,
  output logic                ev_valid,
  input  logic                ev_ready,
  output logic [PTR_W-1:0]    ev_ptr,
  output logic                ev_is_stop
);
  localparam int MAX_MIN = (2**UNIT_W - 1) * UNIT_MIN + (2**OFS_W - 1);
  localparam int TIME_W  = $clog2(MAX_MIN + 1);
  localparam int NCALC   = 3;  // 0: now, 1: start, 2: stop

  sched_t fld;
  logic   day_ok;
  logic [UNIT_W-1:0] calc_u [NCALC];
  logic [OFS_W-1:0]  calc_o [NCALC];
  logic [TIME_W-1:0] calc_m [NCALC];

  tme_field_unpack u_unpack (.raw(entry), .fld(fld));

  always_comb begin
    calc_u[0] = clk_hr2;       calc_o[0] = clk_min;
    calc_u[1] = fld.on_units;  calc_o[1] = fld.on_ofs;
    calc_u[2] = fld.off_units; calc_o[2] = fld.off_ofs;
  end

  for (genvar g = 0; g < NCALC; g++) begin : g_calc
    tme_minute_calc #(.UNIT_MIN(UNIT_MIN), .TIME_W(TIME_W)) u_calc (
      .units(calc_u[g]), .ofs(calc_o[g]), .minutes(calc_m[g])
    );
  end

  tme_day_gate u_day (
    .wmask(fld.wmask), .wday(clk_wday), .yday(clk_yday),
    .first(fld.day_first), .last(fld.day_last), .pass(day_ok)
  );

  logic hit_on, hit_off, slot_free;
  always_comb begin
    hit_on    = min_tick && day_ok && (calc_m[0] == calc_m[1]);
    hit_off   = min_tick && day_ok && (calc_m[0] == calc_m[2]);
    slot_free = !ev_valid || ev_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_valid   <= 1'b0;
      ev_ptr     <= '0;
      ev_is_stop <= 1'b0;
    end else if (slot_free) begin
      ev_valid <= hit_on || hit_off;
      if (hit_on) begin
        ev_ptr     <= fld.on_ptr;
        ev_is_stop <= 1'b0;
      end else if (hit_off) begin
        ev_ptr     <= fld.off_ptr;
        ev_is_stop <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tme_checker.sv
module tme_checker
  import tme_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               min_tick,
  input logic [OFS_W-1:0]   clk_min,
  input logic [UNIT_W-1:0]  clk_hr2,
  input logic [DAY_W-1:0]   clk_yday,
  input logic [WDAY_W-1:0]  clk_wday,
  input logic [ENTRY_W-1:0] entry,
  input logic               ev_valid,
  input logic               ev_ready,
  input logic [PTR_W-1:0]   ev_ptr,
  input logic               ev_is_stop
);
  logic free;
  assign free = !ev_valid || ev_ready;

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !ev_valid);

  p_range_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (min_tick && free &&
     ((clk_yday < {entry[39], entry[63:56]}) || (clk_yday > {entry[31], entry[55:48]})))
    |=> !ev_valid);

  p_bad_wday_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (min_tick && free && clk_wday == 3'd7) |=> !ev_valid);

  p_stop_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_is_stop && $past(min_tick) && $past(free))
    |-> ev_ptr == $past({entry[19:16], entry[7:0]}));

  p_start_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_is_stop && $past(min_tick) && $past(free))
    |-> ev_ptr == $past({entry[23:20], entry[15:8]}));

  p_tick_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!min_tick && free) |=> !ev_valid);

  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_ptr) && $stable(ev_is_stop)));
endmodule

bind timer_event_match tme_checker u_chk (
  .clk(clk), .rst_n(rst_n), .min_tick(min_tick), .clk_min(clk_min),
  .clk_hr2(clk_hr2), .clk_yday(clk_yday), .clk_wday(clk_wday), .entry(entry),
  .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_ptr(ev_ptr), .ev_is_stop(ev_is_stop)
);

// File: tb/timer_event_match_test.sv
`timescale 1ns/1ps
module timer_event_match_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        min_tick = 1'b0;
  logic [6:0]  clk_min = '0;
  logic [3:0]  clk_hr2 = '0;
  logic [8:0]  clk_yday = '0;
  logic [2:0]  clk_wday = '0;
  logic [71:0] entry = '0;
  logic        ev_valid;
  logic        ev_ready = 1'b1;
  logic [11:0] ev_ptr;
  logic        ev_is_stop;

  always #2 clk = ~clk;

  timer_event_match uut (
    .clk(clk), .rst_n(rst_n), .min_tick(min_tick), .clk_min(clk_min),
    .clk_hr2(clk_hr2), .clk_yday(clk_yday), .clk_wday(clk_wday), .entry(entry),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_ptr(ev_ptr), .ev_is_stop(ev_is_stop)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit direct = 1'b1;
  bit rsv = 1'b0;

  typedef struct { bit has; logic [11:0] ptr; bit stp; string tag; } exp_t;
  exp_t sb[$];

  logic tick_q = 1'b0;
  always @(posedge clk) tick_q <= min_tick;

  task automatic check(string tag, bit ok, logic v, logic [11:0] p, logic s,
                       logic ev, logic [11:0] ep, logic es);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b ptr=%h stop=%0b, expected valid=%0b ptr=%h stop=%0b",
               tag, v, p, s, ev, ep, es);
    end
  endtask

  // Monitor: compare each tick result against the scoreboard queue
  always @(negedge clk) begin
    if (!direct && rst_n) begin
      if (tick_q) begin
        exp_t e;
        if (sb.size() == 0) begin
          check("scoreboard underrun", 1'b0, ev_valid, ev_ptr, ev_is_stop, 1'b0, '0, 1'b0);
        end else begin
          e = sb.pop_front();
          check(e.tag, (ev_valid === e.has) &&
                (!e.has || (ev_ptr === e.ptr && ev_is_stop === e.stp)),
                ev_valid, ev_ptr, ev_is_stop, e.has, e.ptr, e.stp);
        end
      end else if (ev_valid) begin
        check("R7 spurious output", 1'b0, ev_valid, ev_ptr, ev_is_stop, 1'b0, '0, 1'b0);
      end
    end
  end

  function automatic logic [71:0] mk(logic [6:0] mask, logic [8:0] sd, logic [8:0] ed,
      logic [3:0] su, logic [6:0] so, logic [3:0] pu, logic [6:0] po,
      logic [11:0] sp, logic [11:0] ep);
    logic [71:0] e;
    e = '0;
    e[71] = rsv;        e[70:64] = mask;
    e[63:56] = sd[7:0]; e[55:48] = ed[7:0];
    e[47:44] = su;      e[43:40] = pu;
    e[39] = sd[8];      e[38:32] = so;
    e[31] = ed[8];      e[30:24] = po;
    e[23:20] = sp[11:8]; e[19:16] = ep[11:8];
    e[15:8] = sp[7:0];  e[7:0] = ep[7:0];
    return e;
  endfunction

  // Driver: called at a negedge, applies one tick and queues the expected result
  task automatic apply(string tag, logic [6:0] mask, int sd, int ed,
      int su, int so, int pu, int po, logic [11:0] sp, logic [11:0] ep,
      int hr2, int mn, int yd, int wd);
    exp_t x;
    bit dok;
    int now, ton, toff;
    entry    = mk(mask, 9'(sd), 9'(ed), 4'(su), 7'(so), 4'(pu), 7'(po), sp, ep);
    clk_hr2  = 4'(hr2); clk_min = 7'(mn); clk_yday = 9'(yd); clk_wday = 3'(wd);
    dok  = (wd < 7) && mask[wd] && (yd >= sd) && (yd <= ed);
    now  = hr2 * 120 + mn; ton = su * 120 + so; toff = pu * 120 + po;
    x.tag = tag;
    x.has = dok && (now == ton || now == toff);
    x.stp = !(now == ton);
    x.ptr = (now == ton) ? sp : ep;
    sb.push_back(x);
    min_tick = 1'b1;
    @(negedge clk);
    min_tick = 1'b0;
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", ev_valid === 1'b0, ev_valid, ev_ptr, ev_is_stop, 1'b0, '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    direct = 1'b0;

    // R4 R5 basic start/stop and mismatch
    apply("R5 start match", 7'h7f, 0, 365, 4, 0, 9, 0, 12'h01d, 12'h022, 4, 0, 10, 3);
    apply("R5 stop match",  7'h7f, 0, 365, 4, 0, 9, 0, 12'h01d, 12'h022, 9, 0, 10, 3);
    apply("R4 off by one minute", 7'h7f, 0, 365, 4, 0, 9, 0, 12'h01d, 12'h022, 4, 1, 10, 3);
    apply("R4 offset carry", 7'h7f, 0, 365, 0, 121, 9, 0, 12'hABC, 12'h5DE, 1, 1, 10, 3);
    apply("R4 offset stop", 7'h7f, 0, 365, 0, 0, 3, 77, 12'hABC, 12'h5DE, 3, 77, 10, 3);
    apply("R5 high ptr bits", 7'h7f, 0, 365, 11, 119, 2, 5, 12'hF0F, 12'hA5A, 11, 119, 200, 6);
    // R3 weekday mask
    apply("R3 monday enabled", 7'h02, 0, 365, 2, 0, 5, 0, 12'h111, 12'h222, 2, 0, 50, 1);
    apply("R3 sunday masked",  7'h02, 0, 365, 2, 0, 5, 0, 12'h111, 12'h222, 2, 0, 50, 0);
    apply("R3 index seven",    7'h7f, 0, 365, 2, 0, 5, 0, 12'h111, 12'h222, 2, 0, 50, 7);
    apply("R3 saturday enabled", 7'h40, 0, 365, 2, 0, 5, 0, 12'h111, 12'h222, 5, 0, 50, 6);
    rsv = 1'b1;
    apply("R3 reserved bit ignored", 7'h00, 0, 365, 2, 0, 5, 0, 12'h111, 12'h222, 2, 0, 50, 2);
    apply("R3 reserved bit set, mask ok", 7'h04, 0, 365, 2, 0, 5, 0, 12'h111, 12'h222, 2, 0, 50, 2);
    rsv = 1'b0;
    // R2 day range ends with high day bit
    apply("R2 below first", 7'h7f, 256, 365, 1, 0, 2, 0, 12'h333, 12'h444, 1, 0, 255, 4);
    apply("R2 first day",   7'h7f, 256, 365, 1, 0, 2, 0, 12'h333, 12'h444, 1, 0, 256, 4);
    apply("R2 last day",    7'h7f, 256, 365, 1, 0, 2, 0, 12'h333, 12'h444, 2, 0, 365, 4);
    apply("R2 above last",  7'h7f, 256, 365, 1, 0, 2, 0, 12'h333, 12'h444, 2, 0, 366, 4);
    // R9 both day tests needed
    apply("R9 weekday ok, day out", 7'h7f, 10, 20, 1, 0, 2, 0, 12'h555, 12'h666, 1, 0, 21, 2);
    apply("R9 day ok, weekday out", 7'h01, 10, 20, 1, 0, 2, 0, 12'h555, 12'h666, 1, 0, 15, 2);
    // R6 equal times
    apply("R6 equal times start wins", 7'h7f, 0, 365, 5, 0, 5, 0, 12'h777, 12'h888, 5, 0, 100, 5);
    apply("R6 equal via offset", 7'h7f, 0, 365, 5, 0, 4, 120, 12'h777, 12'h888, 5, 0, 100, 5);

    // R7 no tick: matching inputs held, no output
    entry = mk(7'h7f, 9'd0, 9'd365, 4'd4, 7'd0, 4'd9, 7'd0, 12'h01d, 12'h022);
    clk_hr2 = 4'd4; clk_min = 7'd0; clk_yday = 9'd10; clk_wday = 3'd3;
    repeat (4) @(negedge clk);
    direct = 1'b1;
    check("R7 no tick no output", ev_valid === 1'b0, ev_valid, ev_ptr, ev_is_stop, 1'b0, '0, 1'b0);

    // R8 stall handling
    ev_ready = 1'b0;
    entry = mk(7'h7f, 9'd0, 9'd365, 4'd4, 7'd0, 4'd9, 7'd0, 12'h0A1, 12'h0B2);
    clk_hr2 = 4'd4; min_tick = 1'b1;
    @(negedge clk);
    check("R8 first result", ev_valid === 1'b1 && ev_ptr === 12'h0A1 && ev_is_stop === 1'b0,
          ev_valid, ev_ptr, ev_is_stop, 1'b1, 12'h0A1, 1'b0);
    clk_hr2 = 4'd9;
    @(negedge clk);
    min_tick = 1'b0;
    check("R8 held under stall", ev_valid === 1'b1 && ev_ptr === 12'h0A1 && ev_is_stop === 1'b0,
          ev_valid, ev_ptr, ev_is_stop, 1'b1, 12'h0A1, 1'b0);
    @(negedge clk);
    check("R8 still held", ev_valid === 1'b1 && ev_ptr === 12'h0A1,
          ev_valid, ev_ptr, ev_is_stop, 1'b1, 12'h0A1, 1'b0);
    ev_ready = 1'b1; min_tick = 1'b1;
    @(negedge clk);
    min_tick = 1'b0;
    check("R8 load on accept", ev_valid === 1'b1 && ev_ptr === 12'h0B2 && ev_is_stop === 1'b1,
          ev_valid, ev_ptr, ev_is_stop, 1'b1, 12'h0B2, 1'b1);
    @(negedge clk);
    check("R8 drained", ev_valid === 1'b0, ev_valid, ev_ptr, ev_is_stop, 1'b0, '0, 1'b0);

    check("scoreboard empty", sb.size() == 0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule